// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the device-side logic of a small serial EEPROM that a host drives over a select line, a serial clock, a data-in line and a data-out line. An organisation strap chooses between 16-bit words and 8-bit bytes. The controller synchronises the serial pins to its own system clock. It waits for a start bit, then collects a two-bit opcode, an address and, when the instruction needs one, a data word. From these it decodes seven instructions: read, write, erase, erase-everything, fill-everything, write enable and write disable.

The storage is a behavioural byte array, so one physical image serves both organisations. In 16-bit mode, word `a` consists of byte `2a` (upper half) and byte `2a+1` (lower half). Writes, erases and fills are gated by a write-enable latch and run a self-timed programming cycle of `PROG_CYCLES` system clocks. While that cycle runs, the host can raise select and watch the data-out line for a ready flag, with no serial clock needed.

Top module: `mw_eeprom_slave`

## Requirements
- R1: With select high, zeros on the data input before the first 1 are ignored. The first 1 sampled on a serial-clock rising edge is the start bit of a frame.
- R2: After the start bit the controller takes a 2-bit opcode, then an address MSB first: `A16` bits when `org`=1 and `A16+1` bits when `org`=0. Data fields are 16 bits (`org`=1) or 8 bits (`org`=0), MSB first.
- R3: Opcode 10 reads. The rising edge that shifts in the last address bit drives a 0 onto `do_o`, and each of the following rising edges presents the next bit of the addressed word, MSB first. A read works whether writes are enabled or not.
- R4: Opcode 01 writes the data field to the address. In 16-bit mode word `a` occupies bytes `2a` (bits 15:8) and `2a+1` (bits 7:0); in 8-bit mode the address selects one byte.
- R5: Opcode 11 sets every bit of the addressed word (or byte) to 1. Opcode 00 with address MSBs 10 sets every location to 1.
- R6: Opcode 00 with address MSBs 01 takes a data field and writes it to every location.
- R7: After reset the controller is write-disabled. A write, erase or fill request made while disabled leaves the storage unchanged.
- R8: Opcode 00 with address MSBs 11 enables writes, and opcode 00 with MSBs 00 disables them. Each takes effect when select falls at the end of its frame. The other address bits are don't-care.
- R9: A permitted program request starts its cycle when select falls after the complete frame. If select is high during that cycle, `do_o` reads 0 while busy and 1 once `PROG_CYCLES` clocks have passed, with no serial clock toggling.
- R10: While a programming cycle runs, a new frame is ignored and has no effect on the storage.
- R11: While select is low, the serial clock and data input have no effect and `do_oe` is low.
- R12: A rising edge on select abandons any partial frame, and the controller waits for a new start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Select from the host, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| org | input | 1 | Organisation strap: 1 = 16-bit words, 0 = 8-bit bytes |
| do_o | output | 1 | Serial data / ready status to the host |
| do_oe | output | 1 | Output enable for `do_o` (high while select is high) |

## Verification
The assertions rely on the host pins changing slowly compared with the system clock. Each serial-clock phase and each select change must last several system clocks, so the synchronised edges arrive one at a time and data is settled before its clock edge. The stimulus holds every pin level for six system clocks. It changes the data input only while the serial clock is low, and it never lets a serial-clock edge coincide with a select edge. Select stays low for at least six clocks between frames, and the strap changes only while select is low.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

   typedef enum logic [2:0] {
      INS_NONE, INS_READ, INS_WRITE, INS_ERASE,
      INS_WEN, INS_WDS, INS_WRALL, INS_ERAL
   } ins_e;

   typedef enum logic [2:0] {
      SO_NONE, SO_WORD, SO_ONES, SO_FILL, SO_ALLONES
   } st_op_e;

   typedef enum logic [2:0] {
      FS_IDLE, FS_WAIT, FS_OPC, FS_ADR, FS_DAT, FS_RD, FS_END
   } fs_e;

   function automatic ins_e decode_ins(input logic [1:0] opc, input logic [1:0] msb);
      ins_e r;
      case (opc)
         2'b10: r = INS_READ;
         2'b01: r = INS_WRITE;
         2'b11: r = INS_ERASE;
         default: begin
            case (msb)
               2'b11:   r = INS_WEN;
               2'b00:   r = INS_WDS;
               2'b01:   r = INS_WRALL;
               default: r = INS_ERAL;
            endcase
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mw_sync_edge.sv
module mw_sync_edge #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mw_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;
   logic [W-1:0]             last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg  <= '0;
         last <= '0;
      end else begin
         stg  <= {stg[STAGES-2:0], d};
         last <= stg[STAGES-1];
      end
   end

   assign lvl  = stg[STAGES-1];
   assign rise = lvl & ~last;
   assign fall = ~lvl & last;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
   parameter int CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("mw_prog_timer: CYCLES must be positive");
      end
   endgenerate

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (start)        cnt <= TW'(CYCLES);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/mw_store.sv
module mw_store
   import mw_eeprom_pkg::*;
#(
   parameter int A16    = 10,
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                org,
   input  st_op_e              op,
   input  logic [A16:0]        addr,
   input  logic [2*BYTE_W-1:0] data,
   input  logic [A16:0]        raddr,
   output logic [2*BYTE_W-1:0] rword
);
   localparam int AW_MAX = A16 + 1;
   localparam int NBYTES = 1 << AW_MAX;
   localparam int WORD_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] mem [NBYTES];
   logic [NBYTES-1:0] hit;
   logic [BYTE_W-1:0] hi_b, lo_b;

   assign hi_b = data[WORD_W-1:BYTE_W];
   assign lo_b = data[BYTE_W-1:0];

   always_comb begin
      for (int i = 0; i < NBYTES; i++) begin
         if (org) hit[i] = ((AW_MAX'(i) >> 1) == {1'b0, addr[A16-1:0]});
         else     hit[i] = (AW_MAX'(i) == addr);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NBYTES; i++) begin
         case (op)
            SO_WORD:    if (hit[i]) mem[i] <= (org && (i % 2 == 0)) ? hi_b : lo_b;
            SO_ONES:    if (hit[i]) mem[i] <= '1;
            SO_FILL:    mem[i] <= (org && (i % 2 == 0)) ? hi_b : lo_b;
            SO_ALLONES: mem[i] <= '1;
            default:    ;
         endcase
      end
   end

   always_comb begin
      if (org) rword = {mem[{raddr[A16-1:0], 1'b0}], mem[{raddr[A16-1:0], 1'b1}]};
      else     rword = {{BYTE_W{1'b0}}, mem[raddr]};
   end
endmodule

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
   import mw_eeprom_pkg::*;
#(
   parameter int A16    = 10,
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                org,
   input  logic                busy,
   input  logic                cs_lvl,
   input  logic                cs_rise,
   input  logic                cs_fall,
   input  logic                sk_rise,
   input  logic                di_lvl,
   input  logic [2*BYTE_W-1:0] rword,
   output logic [A16:0]        raddr,
   output logic                do_bit,
   output logic                cmd_valid,
   output ins_e                cmd_ins,
   output logic [A16:0]        cmd_addr,
   output logic [2*BYTE_W-1:0] cmd_data
);
   localparam int AW_MAX = A16 + 1;
   localparam int WORD_W = 2 * BYTE_W;
   localparam int CW     = $clog2(WORD_W + AW_MAX + 1);

   fs_e               st;
   logic [CW-1:0]     cnt;
   logic [1:0]        opc;
   logic [AW_MAX-1:0] adr;
   logic [WORD_W-1:0] dat, sh;
   ins_e              ins;
   logic              do_q;

   logic [AW_MAX-1:0] adr_nx;
   logic [1:0]        msb_nx;
   ins_e              ins_nx;
   logic [CW-1:0]     aw_last, w_last;

   assign adr_nx  = {adr[AW_MAX-2:0], di_lvl};
   assign msb_nx  = org ? adr_nx[A16-1 -: 2] : adr_nx[A16 -: 2];
   assign ins_nx  = decode_ins(opc, msb_nx);
   assign aw_last = org ? CW'(A16 - 1) : CW'(A16);
   assign w_last  = org ? CW'(WORD_W - 1) : CW'(BYTE_W - 1);
   assign raddr   = adr_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= FS_IDLE; cnt <= '0; opc <= '0; adr <= '0;
         dat <= '0; sh <= '0; ins <= INS_NONE; do_q <= 1'b0;
      end else if (cs_rise) begin
         st <= FS_WAIT; cnt <= '0; do_q <= 1'b0;
      end else if (cs_fall) begin
         st <= FS_IDLE;
      end else if (sk_rise && cs_lvl && !busy) begin
         case (st)
            FS_WAIT: if (di_lvl) begin
               st <= FS_OPC; cnt <= '0; opc <= '0; adr <= '0; dat <= '0;
            end
            FS_OPC: begin
               opc <= {opc[0], di_lvl};
               if (cnt == CW'(1)) begin st <= FS_ADR; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            end
            FS_ADR: begin
               adr <= adr_nx;
               if (cnt == aw_last) begin
                  cnt <= '0;
                  ins <= ins_nx;
                  if (ins_nx == INS_READ) begin
                     st   <= FS_RD;
                     do_q <= 1'b0;
                     sh   <= org ? rword : {rword[BYTE_W-1:0], {BYTE_W{1'b0}}};
                  end else if (ins_nx == INS_WRITE || ins_nx == INS_WRALL) begin
                     st <= FS_DAT;
                  end else begin
                     st <= FS_END;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FS_DAT: begin
               dat <= {dat[WORD_W-2:0], di_lvl};
               if (cnt == w_last) begin st <= FS_END; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            end
            FS_RD: begin
               do_q <= sh[WORD_W-1];
               sh   <= {sh[WORD_W-2:0], 1'b0};
               if (cnt == w_last) begin st <= FS_END; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign cmd_valid = cs_fall && (st == FS_END);
   assign cmd_ins   = ins;
   assign cmd_addr  = adr;
   assign cmd_data  = dat;
   assign do_bit    = do_q;

   // R1
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FS_OPC && $past(st) == FS_WAIT) |-> $past(sk_rise && di_lvl));

   // R10
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (st == FS_WAIT || st == FS_IDLE));

   // R11
   deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_lvl && !cs_fall) |=> $stable(st));

   // R12
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> (st == FS_WAIT));
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
   import mw_eeprom_pkg::*;
#(
   parameter int A16         = 10,
   parameter int BYTE_W      = 8,
   parameter int PROG_CYCLES = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   input  logic org,
   output logic do_o,
   output logic do_oe
);
   localparam int WORD_W = 2 * BYTE_W;

   generate
      if (A16 < 2) begin : g_bad_addr
         $error("mw_eeprom_slave: A16 must be at least 2");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("mw_eeprom_slave: BYTE_W must be positive");
      end
   endgenerate

   logic [2:0]        s_lvl, s_rise, s_fall;
   logic              cs_lvl, cs_rise, cs_fall, sk_rise, di_lvl;
   logic              busy, do_bit, cmd_valid, prog_ok, wen_q, status_q;
   ins_e              cmd_ins;
   logic [A16:0]      cmd_addr, raddr;
   logic [WORD_W-1:0] cmd_data, rword;
   st_op_e            sop;

   mw_sync_edge #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs, sk, di}),
      .lvl(s_lvl), .rise(s_rise), .fall(s_fall));

   assign cs_lvl  = s_lvl[2];
   assign cs_rise = s_rise[2];
   assign cs_fall = s_fall[2];
   assign sk_rise = s_rise[1];
   assign di_lvl  = s_lvl[0];

   mw_frame_rx #(.A16(A16), .BYTE_W(BYTE_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .org(org), .busy(busy),
      .cs_lvl(cs_lvl), .cs_rise(cs_rise), .cs_fall(cs_fall),
      .sk_rise(sk_rise), .di_lvl(di_lvl), .rword(rword), .raddr(raddr),
      .do_bit(do_bit), .cmd_valid(cmd_valid), .cmd_ins(cmd_ins),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data));

   assign prog_ok = cmd_valid && wen_q && !busy &&
                    (cmd_ins == INS_WRITE || cmd_ins == INS_ERASE ||
                     cmd_ins == INS_WRALL || cmd_ins == INS_ERAL);

   always_comb begin
      sop = SO_NONE;
      if (prog_ok) begin
         case (cmd_ins)
            INS_WRITE: sop = SO_WORD;
            INS_ERASE: sop = SO_ONES;
            INS_WRALL: sop = SO_FILL;
            INS_ERAL:  sop = SO_ALLONES;
            default:   sop = SO_NONE;
         endcase
      end
   end

   mw_store #(.A16(A16), .BYTE_W(BYTE_W)) u_store (
      .clk(clk), .org(org), .op(sop), .addr(cmd_addr), .data(cmd_data),
      .raddr(raddr), .rword(rword));

   mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(prog_ok), .busy(busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q    <= 1'b0;
         status_q <= 1'b0;
      end else begin
         if (cmd_valid && cmd_ins == INS_WEN) wen_q <= 1'b1;
         else if (cmd_valid && cmd_ins == INS_WDS) wen_q <= 1'b0;
         if (prog_ok) status_q <= 1'b1;
         else if (cs_rise && !busy) status_q <= 1'b0;
      end
   end

   assign do_o  = status_q ? ~busy : do_bit;
   assign do_oe = cs_lvl;

   // R8
   wen_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wen_q) |-> $past(cs_fall));

   // R9
   prog_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_fall));

   // R7
   prog_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> wen_q);
endmodule

// File: tb/sim_mw_eeprom_slave.sv
module sim_mw_eeprom_slave;
   localparam int A16  = 3;
   localparam int PROG = 100;
   localparam int NB   = 1 << (A16 + 1);

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
   logic do_o, do_oe;
   int   nchk = 0, nerr = 0;
   logic [7:0] refm [NB];

   always #2 clk = ~clk;

   mw_eeprom_slave #(.A16(A16), .BYTE_W(8), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
      .do_o(do_o), .do_oe(do_oe));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic b, output logic s);
      di = b;
      repeat (6) @(negedge clk);
      sk = 1'b1;
      repeat (6) @(negedge clk);
      s  = do_o;
      sk = 1'b0;
   endtask

   task automatic hdr(input logic [1:0] opc, input int adr, input logic o, output logic last);
      logic s;
      int aw;
      aw = o ? A16 : A16 + 1;
      pulse(1'b1, s); pulse(opc[1], s); pulse(opc[0], s);
      for (int k = aw - 1; k >= 0; k--) pulse(adr[k], s);
      last = s;
   endtask

   task automatic sdata(input int d, input logic o);
      logic s;
      for (int k = (o ? 15 : 7); k >= 0; k--) pulse(d[k], s);
   endtask

   task automatic cs_on;
      cs = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic cs_off;
      cs = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic prog_wait(output int n);
      cs = 1'b0;
      n  = 0;
      repeat (4) begin @(negedge clk); n++; end
      cs = 1'b1;
      while (do_o !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
      cs_off();
   endtask

   task automatic do_read(input int adr, input logic o, output int val, output logic dummy);
      logic s;
      org = o;
      cs_on();
      hdr(2'b10, adr, o, dummy);
      val = 0;
      for (int k = 0; k < (o ? 16 : 8); k++) begin
         pulse(1'b0, s);
         val = (val << 1) | int'(s);
      end
      cs_off();
   endtask

   task automatic do_prog(input logic [1:0] opc, input int adr, input int d, input logic o,
                          input bit has_d, input bit runs, output int n);
      logic s;
      org = o;
      cs_on();
      hdr(opc, adr, o, s);
      if (has_d) sdata(d, o);
      n = 0;
      if (runs) prog_wait(n);
      else cs_off();
   endtask

   task automatic ctl(input logic [1:0] ms, input logic o);
      logic s;
      org = o;
      cs_on();
      hdr(2'b00, int'(ms) << ((o ? A16 : A16 + 1) - 2), o, s);
      cs_off();
   endtask

   function automatic int exp16(input int a);
      return {refm[2*a], refm[2*a+1]};
   endfunction

   task automatic check_all(input string tag);
      int v;
      logic dm;
      for (int a = 0; a < NB / 2; a++) begin
         do_read(a, 1'b1, v, dm);
         chk(v == exp16(a), tag, v, exp16(a));
         chk(dm == 1'b0, {tag, " R3 dummy"}, int'(dm), 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int n, v;
      logic dm, s;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(do_oe == 1'b0, "R11 reset do_oe", int'(do_oe), 0);

      // R8 enable, R5 erase everything (MSBs 10), R9 timing
      ctl(2'b11, 1'b1);
      do_prog(2'b00, 2 << (A16 - 2), 0, 1'b1, 1'b0, 1'b1, n);
      chk(n >= PROG && n <= PROG + 8, "R9 ready delay", n, PROG);
      for (int i = 0; i < NB; i++) refm[i] = 8'hFF;
      check_all("R5 eral");

      // R4 word writes, R2 x16 fields
      for (int a = 0; a < NB / 2; a++) begin
         int d;
         d = ((a * 16'h1111) ^ 16'h5A0F) & 16'hFFFF;
         do_prog(2'b01, a, d, 1'b1, 1'b1, 1'b1, n);
         chk(n >= PROG && n <= PROG + 8, "R9 write ready", n, PROG);
         refm[2*a] = d[15:8];
         refm[2*a+1] = d[7:0];
      end
      check_all("R4 x16 write");

      // R2 byte view
      for (int b = 0; b < NB; b++) begin
         do_read(b, 1'b0, v, dm);
         chk(v == int'(refm[b]), "R2 x8 read", v, int'(refm[b]));
      end

      // R4 byte writes
      do_prog(2'b01, 5, 8'h96, 1'b0, 1'b1, 1'b1, n);  refm[5]  = 8'h96;
      do_prog(2'b01, 10, 8'h3C, 1'b0, 1'b1, 1'b1, n); refm[10] = 8'h3C;
      check_all("R4 x8 write");

      // R5 single erase
      do_prog(2'b11, 3, 0, 1'b1, 1'b0, 1'b1, n);
      refm[6] = 8'hFF; refm[7] = 8'hFF;
      check_all("R5 erase");

      // R10 frame during busy, R9 busy status without clock
      org = 1'b1;
      cs_on();
      hdr(2'b01, 6, 1'b1, s);
      sdata(16'h1234, 1'b1);
      cs = 1'b0;
      repeat (4) @(negedge clk);
      cs = 1'b1;
      repeat (6) @(negedge clk);
      chk(do_o == 1'b0, "R9 busy status", int'(do_o), 0);
      chk(do_oe == 1'b1, "R11 do_oe high", int'(do_oe), 1);
      hdr(2'b11, 2, 1'b1, s);
      n = 0;
      while (do_o !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
      chk(do_o == 1'b1, "R9 ready status", int'(do_o), 1);
      cs_off();
      refm[12] = 8'h12; refm[13] = 8'h34;
      check_all("R10 ignored frame");

      // R1 leading zeros
      cs_on();
      repeat (5) pulse(1'b0, s);
      hdr(2'b10, 6, 1'b1, dm);
      v = 0;
      for (int k = 0; k < 16; k++) begin pulse(1'b0, s); v = (v << 1) | int'(s); end
      cs_off();
      chk(v == 16'h1234, "R1 leading zeros", v, 16'h1234);

      // R12 partial frame abandoned by select
      cs_on();
      pulse(1'b1, s); pulse(1'b0, s); pulse(1'b1, s); pulse(1'b0, s);
      cs = 1'b0;
      repeat (6) @(negedge clk);
      cs_on();
      hdr(2'b10, 6, 1'b1, dm);
      v = 0;
      for (int k = 0; k < 16; k++) begin pulse(1'b0, s); v = (v << 1) | int'(s); end
      cs_off();
      chk(v == 16'h1234, "R12 restart", v, 16'h1234);

      // R11 clocking while deselected
      pulse(1'b1, s); pulse(1'b0, s); pulse(1'b1, s);
      for (int k = 0; k < A16 + 16; k++) begin
         pulse(1'b0, s);
         chk(do_oe == 1'b0, "R11 do_oe low", int'(do_oe), 0);
      end
      check_all("R11 no effect");

      // R6 fill in both organisations
      do_prog(2'b00, 1 << (A16 - 2), 16'hA5C3, 1'b1, 1'b1, 1'b1, n);
      for (int a = 0; a < NB / 2; a++) begin refm[2*a] = 8'hA5; refm[2*a+1] = 8'hC3; end
      check_all("R6 fill x16");
      do_prog(2'b00, 1 << (A16 - 1), 8'h3C, 1'b0, 1'b1, 1'b1, n);
      for (int i = 0; i < NB; i++) refm[i] = 8'h3C;
      check_all("R6 fill x8");

      // R8 disable, R7 dropped requests
      ctl(2'b00, 1'b1);
      do_prog(2'b01, 1, 16'h0BAD, 1'b1, 1'b1, 1'b0, n);
      do_prog(2'b00, 2 << (A16 - 2), 0, 1'b1, 1'b0, 1'b0, n);
      do_prog(2'b11, 0, 0, 1'b0, 1'b0, 1'b0, n);
      check_all("R7 disabled");

      // R7 reset returns to disabled
      ctl(2'b11, 1'b1);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      do_prog(2'b01, 4, 16'h7777, 1'b1, 1'b1, 1'b0, n);
      check_all("R7 after reset");

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule